// File: doc/BRIEF.md
# Serial Game-Pad Read Port

This block sits on a CPU bus and presents two serial game-pad ports. Each pad has eight parallel button lines. A write to the strobe address sets or clears one strobe that both pads share. While the strobe is high, each pad's shift register keeps reloading from its live button lines. Once the strobe is low, every read of a pad's address returns the next button in bit 0 and shifts that pad's register by one place.

The bits of a pad read above bit 0 are not driven by the pads. They repeat the last value that crossed the data bus, so software sees the usual open-bus pattern. A latch tracks every bus data phase for this purpose: the write data, the data returned by other devices on reads, and the block's own read result.

Each read is answered in the same cycle. `pad_rdata` is combinational from the registered state, and the shift and latch updates take effect at the clock edge that ends the access.

Top module: `pad_serial_port`

## Requirements
- R1: A write to address 0x4016 sets the shared strobe to data bit 0. The strobe applies to both pads.
- R2: While the strobe is high, a pad read returns that pad's live button at index 0 in bit 0, and reads do not advance the pad.
- R3: After the strobe falls, successive reads of a pad return the buttons latched at the falling write, from index 0 upward, in bit 0. The order is index 0 A, 1 B, 2 Select, 3 Start, 4 Up, 5 Down, 6 Left, 7 Right, and 1 means pressed.
- R4: Once all eight buttons of a pad have been read, every further read of that pad returns 1 in bit 0.
- R5: Pad 0 is read at 0x4016 and pad 1 at 0x4017 (pad_buttons[7:0] and pad_buttons[15:8]). Reading one pad never shifts the other.
- R6: Bits 7:1 of a pad read equal bits 7:1 of the previous bus data phase. That phase is the write data, the foreign read data on bus_rdata_in, or the block's own read result.
- R7: After reset the strobe is low, both pads read 1 in bit 0, and the open-bus latch holds 0.
- R8: pad_rdata_valid is high exactly during a read of 0x4016 or 0x4017.
- R9: Writes to any address other than 0x4016, including 0x4017, leave the strobe unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Bus access in this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write data |
| bus_rdata_in | input | 8 | Data returned by other devices on reads |
| pad_buttons | input | 16 | Live buttons, pad 0 in [7:0], pad 1 in [15:8], 1 = pressed |
| pad_rdata | output | 8 | Read result: open-bus bits 7:1, button bit 0 |
| pad_rdata_valid | output | 1 | High while a pad address is being read |

## Verification
The hardest situation to reach is one pad partway through its sequence while the other pad is read, a write hits 0x4017, and the live buttons have already changed since the latch. Each sweep pattern gets there in a fixed order:
- it drops the strobe, then scrambles the live buttons;
- it reads pad 0 three times;
- it reads a foreign address and drains pad 1 past its end;
- it writes 0x4017;
- it finishes pad 0 past its end.

The sweep covers all 256 pad 0 patterns. A foreign write before each pattern gives the open-bus bits a distinct history.

// File: rtl/pad_port_pkg.sv
`timescale 1ns/1ps
package pad_port_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_READ  = 2'd2
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic valid, input logic we);
      if (!valid)  return ACC_NONE;
      else if (we) return ACC_WRITE;
      else         return ACC_READ;
   endfunction
endpackage

// File: rtl/pad_addr_decode.sv
`timescale 1ns/1ps
module pad_addr_decode
   import pad_port_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int NUM_PADS = 2,
   parameter logic [ADDR_W-1:0] STROBE_ADDR = 16'h4016,
   parameter logic [ADDR_W-1:0] PAD_BASE = 16'h4016
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_valid,
   input  logic                cpu_we,
   input  logic [ADDR_W-1:0]   cpu_addr,
   output logic                strobe_wr,
   output logic [NUM_PADS-1:0] rd_hit,
   output logic                any_rd_hit
);
   acc_kind_e kind;

   assign kind = classify(cpu_valid, cpu_we);
   assign strobe_wr = (kind == ACC_WRITE) && (cpu_addr == STROBE_ADDR);

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_hit
      localparam logic [ADDR_W-1:0] PAD_ADDR = PAD_BASE + ADDR_W'(p);
      assign rd_hit[p] = (kind == ACC_READ) && (cpu_addr == PAD_ADDR);
   end

   assign any_rd_hit = |rd_hit;

   assert_onehot_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_hit));
endmodule

// File: rtl/pad_strobe_reg.sv
`timescale 1ns/1ps
module pad_strobe_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_wr,
   input  logic wr_bit,
   output logic strobe
);
   always_ff @(posedge clk) begin
      if (!rst_n)         strobe <= 1'b0;
      else if (strobe_wr) strobe <= wr_bit;
   end

   assert_strobe_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_wr |=> strobe == $past(wr_bit));
   assert_strobe_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_wr |=> $stable(strobe));
endmodule

// File: rtl/pad_shift_chan.sv
`timescale 1ns/1ps
module pad_shift_chan #(
   parameter int   NUM_BUTTONS = 8,
   parameter logic FILL_BIT = 1'b1,
   parameter bit   LIVE_WHILE_STROBE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   strobe,
   input  logic                   rd_en,
   input  logic [NUM_BUTTONS-1:0] buttons,
   output logic                   serial_bit
);
   localparam int TOP = NUM_BUTTONS - 1;

   logic [TOP:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n)      shreg <= {NUM_BUTTONS{FILL_BIT}};
      else if (strobe) shreg <= buttons;
      else if (rd_en)  begin
         if (NUM_BUTTONS > 1) shreg <= {FILL_BIT, shreg[TOP:1]};
         else                 shreg <= FILL_BIT;
      end
   end

   if (LIVE_WHILE_STROBE) begin : g_live
      assign serial_bit = strobe ? buttons[0] : shreg[0];
   end else begin : g_reg
      assign serial_bit = shreg[0];
   end

   assert_fill_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !strobe) |=> shreg[TOP] == FILL_BIT);
   assert_no_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !strobe) |=> $stable(shreg));
endmodule

// File: rtl/pad_open_bus.sv
`timescale 1ns/1ps
module pad_open_bus
   import pad_port_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_we,
   input  logic              own_rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] foreign_rdata,
   input  logic [DATA_W-1:0] own_rdata,
   output logic [DATA_W-1:0] ob_q
);
   acc_kind_e   kind;
   logic [DATA_W-1:0] phase_data;

   assign kind = classify(cpu_valid, cpu_we);

   always_comb begin
      phase_data = ob_q;
      case (kind)
         ACC_WRITE: phase_data = wdata;
         ACC_READ:  phase_data = own_rd ? own_rdata : foreign_rdata;
         default:   phase_data = ob_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ob_q <= '0;
      else        ob_q <= phase_data;
   end

   assert_ob_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_we) |=> ob_q == $past(wdata));
   assert_ob_foreign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !cpu_we && !own_rd) |=> ob_q == $past(foreign_rdata));
   assert_ob_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_valid |=> $stable(ob_q));
endmodule

// File: rtl/pad_serial_port.sv
`timescale 1ns/1ps
module pad_serial_port #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int NUM_PADS = 2,
   parameter int NUM_BUTTONS = 8,
   parameter logic [ADDR_W-1:0] STROBE_ADDR = 16'h4016,
   parameter logic [ADDR_W-1:0] PAD_BASE = 16'h4016,
   parameter logic FILL_BIT = 1'b1,
   parameter bit   LIVE_WHILE_STROBE = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cpu_valid,
   input  logic                            cpu_we,
   input  logic [ADDR_W-1:0]               cpu_addr,
   input  logic [DATA_W-1:0]               cpu_wdata,
   input  logic [DATA_W-1:0]               bus_rdata_in,
   input  logic [NUM_PADS*NUM_BUTTONS-1:0] pad_buttons,
   output logic [DATA_W-1:0]               pad_rdata,
   output logic                            pad_rdata_valid
);
   if (NUM_BUTTONS < 1) begin : g_bad_buttons
      $error("NUM_BUTTONS must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (NUM_PADS < 1) begin : g_bad_pads
      $error("NUM_PADS must be at least 1");
   end

   logic                strobe_wr;
   logic                strobe;
   logic [NUM_PADS-1:0] rd_hit;
   logic                any_rd_hit;
   logic [NUM_PADS-1:0] pad_bit;
   logic                sel_bit;
   logic [DATA_W-1:0]   ob_q;

   pad_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_PADS(NUM_PADS),
      .STROBE_ADDR(STROBE_ADDR), .PAD_BASE(PAD_BASE)
   ) u_dec (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .strobe_wr(strobe_wr), .rd_hit(rd_hit), .any_rd_hit(any_rd_hit)
   );

   pad_strobe_reg u_strobe (
      .clk(clk), .rst_n(rst_n),
      .strobe_wr(strobe_wr), .wr_bit(cpu_wdata[0]), .strobe(strobe)
   );

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      pad_shift_chan #(
         .NUM_BUTTONS(NUM_BUTTONS), .FILL_BIT(FILL_BIT),
         .LIVE_WHILE_STROBE(LIVE_WHILE_STROBE)
      ) u_chan (
         .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd_en(rd_hit[p]),
         .buttons(pad_buttons[p*NUM_BUTTONS +: NUM_BUTTONS]),
         .serial_bit(pad_bit[p])
      );
   end

   assign sel_bit = |(pad_bit & rd_hit);
   assign pad_rdata = {ob_q[DATA_W-1:1], sel_bit};
   assign pad_rdata_valid = any_rd_hit;

   pad_open_bus #(.DATA_W(DATA_W)) u_ob (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_we(cpu_we), .own_rd(any_rd_hit),
      .wdata(cpu_wdata), .foreign_rdata(bus_rdata_in), .own_rdata(pad_rdata),
      .ob_q(ob_q)
   );

   assert_live_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[0] && strobe) |-> pad_rdata[0] == pad_buttons[0]);
   assert_ob_own_R6: assert property (@(posedge clk) disable iff (!rst_n)
      any_rd_hit |=> ob_q == $past(pad_rdata));
endmodule

// File: tb/test_pad_serial_port.sv
`timescale 1ns/1ps
module test_pad_serial_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  bus_rdata_in = '0;
   logic [7:0]  btn0 = '0;
   logic [7:0]  btn1 = '0;
   logic [7:0]  pad_rdata;
   logic        pad_rdata_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] ob_m = '0;
   bit         strobe_m = 1'b0;
   logic [7:0] lat_m [2];
   int         cnt_m [2];

   always #2.5 clk = ~clk;

   pad_serial_port i_pad_serial_port (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .bus_rdata_in(bus_rdata_in),
      .pad_buttons({btn1, btn0}), .pad_rdata(pad_rdata),
      .pad_rdata_valid(pad_rdata_valid)
   );

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic acc(input bit we, input logic [15:0] a, input logic [7:0] wd,
                      input logic [7:0] busd, output logic [7:0] rd, output logic rv);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; bus_rdata_in = busd;
      #1;
      rd = pad_rdata; rv = pad_rdata_valid;
      @(posedge clk);
      #0.5;
      cpu_valid = 1'b0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      logic [7:0] rd;
      logic rv;
      acc(1'b1, a, d, 8'h00, rd, rv);
      chk(rv == 1'b0, "R8", {7'd0, rv}, 8'h00);
      if (a == 16'h4016) begin
         strobe_m = d[0];
         lat_m[0] = btn0; lat_m[1] = btn1;
         cnt_m[0] = 0; cnt_m[1] = 0;
      end
      ob_m = d;
   endtask

   task automatic rd_pad(input int p, input string req);
      logic [7:0] rd, exp;
      logic rv;
      logic b;
      acc(1'b0, (p == 0) ? 16'h4016 : 16'h4017, 8'h00, 8'hC3, rd, rv);
      if (strobe_m) b = (p == 0) ? btn0[0] : btn1[0];
      else if (cnt_m[p] < 8) b = lat_m[p][cnt_m[p]];
      else b = 1'b1;
      if (!strobe_m) cnt_m[p]++;
      exp = {ob_m[7:1], b};
      chk(rd == exp, req, rd, exp);
      chk(rv == 1'b1, "R8", {7'd0, rv}, 8'h01);
      ob_m = exp;
   endtask

   task automatic rd_foreign(input logic [7:0] busd);
      logic [7:0] rd;
      logic rv;
      acc(1'b0, 16'h4018, 8'h00, busd, rd, rv);
      chk(rv == 1'b0, "R8", {7'd0, rv}, 8'h00);
      ob_m = busd;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cnt_m[0] = 8; cnt_m[1] = 8;
      lat_m[0] = 8'hFF; lat_m[1] = 8'hFF;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R7: reset state, both pads exhausted, latch zero
      rd_pad(0, "R7");
      rd_pad(1, "R7");
      // R9: write to 0x4017 and to RAM must not raise strobe
      wr(16'h4017, 8'h01);
      rd_pad(0, "R9");
      wr(16'h0000, 8'h01);
      rd_pad(1, "R9");

      for (int pat = 0; pat < 256; pat++) begin
         btn0 = 8'(pat);
         btn1 = 8'(pat * 37 + 11);
         wr(16'h0000, 8'(pat) ^ 8'h5A);
         // R1: strobe from bit 0, other data bits irrelevant
         wr(16'h4016, {btn0[7:1], 1'b1});
         rd_pad(0, "R2");
         rd_pad(0, "R2");
         btn0 = ~btn0;
         rd_pad(0, "R2");
         rd_pad(1, "R2");
         btn0 = 8'(pat);
         wr(16'h4016, {btn1[7:1], 1'b0});
         // latched values must survive live changes
         btn0 = 8'(pat * 91 + 3);
         btn1 = ~btn1;
         rd_pad(0, "R3");
         rd_pad(0, "R3");
         rd_pad(0, "R3");
         rd_foreign(8'(pat) ^ 8'hA6);
         for (int k = 0; k < 9; k++) rd_pad(1, (k < 8) ? "R5" : "R4");
         wr(16'h4017, 8'h01);
         for (int k = 3; k < 10; k++) rd_pad(0, (k < 8) ? "R3" : "R4");
         rd_foreign(8'(pat));
         rd_pad(0, "R6");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule